// File: doc/BRIEF.md
# Expansion Bus Peripheral Decoder

This block models a peripheral on the parallel expansion bus of an 8-bit home computer. It runs on a fast system clock and samples the slower bus phase clock as an ordinary input. A two-flop synchronizer and an edge detector find the phase edges. A fixed number of system clocks after the phase falls, the block captures the address and the read/write line. A fixed number of system clocks after the phase rises, it captures write data. The captured values drive everything else the block does.

When software sets the device-enable bit in a control register, the peripheral holds its math-pack-disable output low. It then takes over the host's high ROM region. Part of that region is served from an internal firmware ROM and part from a small internal RAM. A second control bit opens a cartridge-bank window, which the peripheral also claims whether or not the device is enabled. Each time it claims a cycle, the block pulls its external-select output low after a short fixed lag. On read cycles it drives the data bus.

Top module: `xbus_dev`

## Requirements
- R1: During and after reset, and until a control write: mpd_n is 1, exsel_n is 1 and data_oe is 0. The device-enable and bank flags are both 0.
- R2: The address and rw_in are captured a fixed ADDR_DLY system clocks after a falling phase edge is detected. Write data is captured DATA_DLY clocks after a rising edge. exsel_n reflects a newly presented address no earlier than the synchronizer, ADDR_DLY and SEL_DLY lags allow.
- R3: A write (rw_in = 0) to 0xD1FF loads bit 0 as the device-enable flag and bit 1 as the bank flag. While the enable flag is 1, mpd_n is held low.
- R4: While the enable flag is 1, a captured address in 0xD800–0xDFFF drives exsel_n low.
- R5: While the bank flag is 1, a captured address in 0xA000–0xBFFF drives exsel_n low, whatever the enable flag holds.
- R6: exsel_n is high whenever neither window condition holds. It follows the condition SEL_DLY system clocks after the address capture.
- R7: Reads in 0xD800–0xDDFF and 0xA000–0xBFFF return the firmware byte addr[7:0] XOR {addr[12:8], 3'b101}.
- R8: With the enable flag set, a write in 0xDE00–0xDFFF stores the byte into RAM at addr[8:0] when write data is captured. Later reads of that address return it.
- R9: Writes into the ROM window (0xD800–0xDDFF) or the bank window leave the data read back there unchanged.
- R10: data_oe is 1 only while exsel_n is low on a read cycle. On write cycles it is 0.
- R11: Writes to 0xD1xx addresses other than 0xD1FF leave the control flags, and so mpd_n, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast system clock |
| rst_n | input | 1 | active-low reset |
| phi_in | input | 1 | bus phase clock, asynchronous to clk |
| addr_in | input | 16 | bus address |
| rw_in | input | 1 | 1 = read cycle, 0 = write cycle |
| data_in | input | 8 | bus write data |
| data_out | output | 8 | read data for the bus |
| data_oe | output | 1 | read data output enable |
| mpd_n | output | 1 | active-low math-pack-disable |
| exsel_n | output | 1 | active-low external-select |

## Verification
The bench uses the default parameters: ADDR_DLY = 5, DATA_DLY = 5, SEL_DLY = 2 and a 9-bit RAM address. The bus phase is 12 system clocks per half. Both capture strobes therefore land well inside their phase half. The lag from a new address to the external-select change can be bounded between two sample points of one bus cycle. The 9-bit RAM index lets the bench reach both ends of the RAM window, 0xDE00 and 0xDFFF. The bench also probes the window edges 0xD7FF, 0xDDFF, 0xBFFF and 0xC000.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_ROM  = 2'd1,
    WIN_RAM  = 2'd2,
    WIN_BANK = 2'd3
  } win_e;

  localparam logic [15:0] CTRL_ADDR = 16'hD1FF;

  // which device window an address falls into
  function automatic win_e classify(input logic [15:0] a);
    if (a >= 16'hD800 && a <= 16'hDDFF)      return WIN_ROM;
    else if (a >= 16'hDE00)                  return (a <= 16'hDFFF) ? WIN_RAM : WIN_NONE;
    else if (a >= 16'hA000 && a <= 16'hBFFF) return WIN_BANK;
    else                                     return WIN_NONE;
  endfunction

  // stand-in firmware content, computed rather than stored
  function automatic logic [7:0] rom_byte(input logic [15:0] a);
    return a[7:0] ^ {a[12:8], 3'b101};
  endfunction

endpackage

// File: rtl/xbus_phase_strobe.sv
module xbus_phase_strobe #(
  parameter int unsigned ADDR_DLY = 5,
  parameter int unsigned DATA_DLY = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic phi_in,
  output logic addr_stb,
  output logic data_stb
);
  localparam int unsigned MAXD = (ADDR_DLY > DATA_DLY) ? ADDR_DLY : DATA_DLY;
  localparam int unsigned CW   = $clog2(MAXD + 1) + 1;

  logic s1, s2, s3;
  logic phi_fall, phi_rise;
  logic [1:0] trig;
  logic [1:0] stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1; s3 <= 1'b1;
    end else begin
      s1 <= phi_in; s2 <= s1; s3 <= s2;
    end
  end

  assign phi_fall = s3 & ~s2;
  assign phi_rise = s2 & ~s3;
  assign trig     = {phi_rise, phi_fall};

  for (genvar k = 0; k < 2; k++) begin : g_ch
    localparam int unsigned D = (k == 0) ? ADDR_DLY : DATA_DLY;
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (trig[k])        cnt <= CW'(D);
      else if (cnt != '0)      cnt <= cnt - 1'b1;
    end
    assign stb[k] = (cnt == CW'(1));
  end

  assign addr_stb = stb[0];
  assign data_stb = stb[1];

  AST_ADDR_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_stb |=> !addr_stb); // R2
  AST_DATA_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    data_stb |=> !data_stb); // R2

endmodule

// File: rtl/xbus_sel_delay.sv
module xbus_sel_delay #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond_in,
  output logic act_out
);
  logic [DEPTH-1:0] pipe;

  if (DEPTH == 1) begin : g_one
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= cond_in;
    end
  end else begin : g_many
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[DEPTH-2:0], cond_in};
    end
  end

  assign act_out = pipe[DEPTH-1];

  AST_SEL_STARTS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_out) |-> $past(pipe[0] || cond_in)); // R6

endmodule

// File: rtl/xbus_ram.sv
module xbus_ram #(
  parameter int unsigned AW = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

  AST_RAM_STORES: assert property (@(posedge clk)
    we |=> mem[$past(waddr)] == $past(wdata)); // R8

endmodule

// File: rtl/xbus_dev.sv
module xbus_dev #(
  parameter int unsigned ADDR_DLY = 5,
  parameter int unsigned DATA_DLY = 5,
  parameter int unsigned SEL_DLY  = 2,
  parameter int unsigned RAM_AW   = 9,
  parameter int unsigned EN_BIT   = 0,
  parameter int unsigned BANK_BIT = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        phi_in,
  input  logic [15:0] addr_in,
  input  logic        rw_in,
  input  logic [7:0]  data_in,
  output logic [7:0]  data_out,
  output logic        data_oe,
  output logic        mpd_n,
  output logic        exsel_n
);
  import xbus_pkg::*;

  logic              addr_stb, data_stb;
  logic [15:0]       addr_lat;
  logic              rw_lat;
  logic              en_q, bank_q;
  win_e              win;
  logic              wr_now, reg_hit, ram_we;
  logic              claim, act;
  logic [7:0]        ram_rd;
  logic [RAM_AW-1:0] ram_idx;

  xbus_phase_strobe #(.ADDR_DLY(ADDR_DLY), .DATA_DLY(DATA_DLY)) u_phase (
    .clk(clk), .rst_n(rst_n), .phi_in(phi_in),
    .addr_stb(addr_stb), .data_stb(data_stb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_lat <= '0;
      rw_lat   <= 1'b1;
    end else if (addr_stb) begin
      addr_lat <= addr_in;
      rw_lat   <= rw_in;
    end
  end

  assign win     = classify(addr_lat);
  assign ram_idx = addr_lat[RAM_AW-1:0];
  assign wr_now  = data_stb && !rw_lat;
  assign reg_hit = (addr_lat == CTRL_ADDR);
  assign ram_we  = wr_now && en_q && (win == WIN_RAM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      bank_q <= 1'b0;
    end else if (wr_now && reg_hit) begin
      en_q   <= data_in[EN_BIT];
      bank_q <= data_in[BANK_BIT];
    end
  end

  xbus_ram #(.AW(RAM_AW)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_idx), .wdata(data_in),
    .raddr(ram_idx), .rdata(ram_rd)
  );

  assign claim = (en_q && (win == WIN_ROM || win == WIN_RAM)) ||
                 (bank_q && win == WIN_BANK);

  xbus_sel_delay #(.DEPTH(SEL_DLY)) u_sel (
    .clk(clk), .rst_n(rst_n), .cond_in(claim), .act_out(act)
  );

  assign exsel_n  = ~act;
  assign mpd_n    = ~en_q;
  assign data_oe  = act && rw_lat;
  assign data_out = (win == WIN_RAM) ? ram_rd : rom_byte(addr_lat);

  AST_MPD_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(mpd_n) |-> $past(data_stb)); // R3
  AST_OE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> !exsel_n); // R10
  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_now && reg_hit) |=> $stable(mpd_n)); // R11

endmodule

// File: tb/sim_xbus_dev.sv
`timescale 1ns/1ps
module sim_xbus_dev;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        phi_in = 1'b1;
  logic [15:0] addr_in = '0;
  logic        rw_in = 1'b1;
  logic [7:0]  data_in = '0;
  logic [7:0]  data_out;
  logic        data_oe, mpd_n, exsel_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  xbus_dev u0 (
    .clk(clk), .rst_n(rst_n), .phi_in(phi_in), .addr_in(addr_in),
    .rw_in(rw_in), .data_in(data_in), .data_out(data_out),
    .data_oe(data_oe), .mpd_n(mpd_n), .exsel_n(exsel_n)
  );

  // firmware byte restated: low byte with bits of addr[12:8] folded in above 3'b101
  function automatic logic [7:0] fw_ref(input logic [15:0] a);
    logic [7:0] mix;
    mix = (8'(a[12:8]) << 3) | 8'h05;
    return a[7:0] ^ mix;
  endfunction

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  logic [7:0] r_data;
  logic       r_oe, r_ex_early, r_ex_late, r_mpd;

  // one bus cycle: phase low 12 clocks, phase high 12 clocks
  task automatic bus(input logic [15:0] a, input logic rw, input logic [7:0] wd);
    @(negedge clk);
    phi_in = 1'b0; addr_in = a; rw_in = rw; data_in = wd;
    repeat (8) @(negedge clk);
    r_ex_early = exsel_n;
    repeat (3) @(negedge clk);
    r_ex_late = exsel_n;
    repeat (1) @(negedge clk);
    phi_in = 1'b1;
    repeat (11) @(negedge clk);
    r_data = data_out; r_oe = data_oe; r_mpd = mpd_n;
  endtask

  task automatic t_reset();
    chk("R1", "mpd_n", 8'(mpd_n), 8'd1);
    chk("R1", "exsel_n", 8'(exsel_n), 8'd1);
    chk("R1", "data_oe", 8'(data_oe), 8'd0);
    bus(16'hD800, 1'b1, 8'h00);
    chk("R1", "exsel_n idle D800", 8'(r_late_or(r_ex_late)), 8'd1);
    chk("R6", "oe with enable off", 8'(r_oe), 8'd0);
  endtask

  function automatic logic r_late_or(input logic v);
    return v;
  endfunction

  task automatic t_enable_rom();
    bus(16'hD1FF, 1'b0, 8'h01);
    chk("R10", "oe on register write", 8'(r_oe), 8'd0);
    bus(16'hD800, 1'b1, 8'h00);
    chk("R3", "mpd_n after enable", 8'(r_mpd), 8'd0);
    chk("R4", "exsel_n D800", 8'(exsel_n), 8'd0);
    chk("R10", "oe D800 read", 8'(r_oe), 8'd1);
    chk("R7", "rom D800", r_data, fw_ref(16'hD800));
    bus(16'hDDFF, 1'b1, 8'h00);
    chk("R7", "rom DDFF", r_data, fw_ref(16'hDDFF));
    bus(16'hDA37, 1'b1, 8'h00);
    chk("R7", "rom DA37", r_data, fw_ref(16'hDA37));
  endtask

  task automatic t_ram();
    bus(16'hDE00, 1'b0, 8'h5A);
    chk("R10", "oe on RAM write", 8'(r_oe), 8'd0);
    chk("R4", "exsel_n on RAM write", 8'(exsel_n), 8'd0);
    bus(16'hDFFF, 1'b0, 8'hC3);
    bus(16'hDE00, 1'b1, 8'h00);
    chk("R8", "ram DE00", r_data, 8'h5A);
    bus(16'hDFFF, 1'b1, 8'h00);
    chk("R8", "ram DFFF", r_data, 8'hC3);
    bus(16'hD900, 1'b0, 8'h77);
    bus(16'hD900, 1'b1, 8'h00);
    chk("R9", "rom D900 after write", r_data, fw_ref(16'hD900));
  endtask

  task automatic t_edges_and_lag();
    bus(16'hD7FF, 1'b1, 8'h00);
    chk("R6", "exsel_n D7FF", 8'(exsel_n), 8'd1);
    chk("R6", "oe D7FF", 8'(r_oe), 8'd0);
    bus(16'hE000, 1'b1, 8'h00);
    chk("R6", "exsel_n E000", 8'(exsel_n), 8'd1);
    bus(16'hD800, 1'b1, 8'h00);
    chk("R2", "exsel_n before capture lag", 8'(r_ex_early), 8'd1);
    chk("R6", "exsel_n after capture lag", 8'(r_ex_late), 8'd0);
    bus(16'hC123, 1'b1, 8'h00);
    chk("R2", "exsel_n release lag", 8'(r_ex_early), 8'd0);
    chk("R6", "exsel_n released", 8'(r_ex_late), 8'd1);
  endtask

  task automatic t_reg_page();
    bus(16'hD1FE, 1'b0, 8'h00);
    bus(16'hD100, 1'b0, 8'h00);
    bus(16'hD800, 1'b1, 8'h00);
    chk("R11", "mpd_n after other D1xx writes", 8'(r_mpd), 8'd0);
    chk("R11", "exsel_n D800 still claimed", 8'(exsel_n), 8'd0);
  endtask

  task automatic t_bank();
    bus(16'hD1FF, 1'b0, 8'h02);
    bus(16'hA000, 1'b1, 8'h00);
    chk("R3", "mpd_n with enable cleared", 8'(r_mpd), 8'd1);
    chk("R5", "exsel_n A000", 8'(exsel_n), 8'd0);
    chk("R7", "bank A000", r_data, fw_ref(16'hA000));
    bus(16'hBFFF, 1'b1, 8'h00);
    chk("R5", "exsel_n BFFF", 8'(exsel_n), 8'd0);
    chk("R7", "bank BFFF", r_data, fw_ref(16'hBFFF));
    bus(16'hC000, 1'b1, 8'h00);
    chk("R6", "exsel_n C000", 8'(exsel_n), 8'd1);
    bus(16'hD800, 1'b1, 8'h00);
    chk("R5", "D800 not claimed without enable", 8'(exsel_n), 8'd1);
    bus(16'hA555, 1'b0, 8'hEE);
    bus(16'hA555, 1'b1, 8'h00);
    chk("R9", "bank A555 after write", r_data, fw_ref(16'hA555));
    chk("R10", "oe bank read", 8'(r_oe), 8'd1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset_pre();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_enable_rom();
    t_ram();
    t_edges_and_lag();
    t_reg_page();
    t_bank();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic t_reset_pre();
    chk("R1", "mpd_n in reset", 8'(mpd_n), 8'd1);
    chk("R1", "exsel_n in reset", 8'(exsel_n), 8'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule